// File: doc/BRIEF.md
# Snooping MESI Line Controller with Bus-Wait States

This block keeps the coherence state of one cache line of a write-back cache that sits on an atomic snooping bus. The processor side presents read or write requests for the line. The controller either answers with a one-cycle done pulse or holds the processor stalled while it obtains the bus. The bus side raises a bus request, waits for the arbiter's grant and then issues a read, a read-for-ownership or an ownership upgrade. At the same time it watches transactions from other caches that target this line, flushes the line when it holds the only up-to-date copy, and downgrades or invalidates its state.

Three wait states cover the time between a bus request and its grant: read pending, write-miss pending and upgrade pending. Snoops are still serviced during these states. A conflicting read-for-ownership that arrives while an upgrade is pending invalidates the line and turns the pending request into a full read-for-ownership. The write then completes at the grant edge itself, so no later snoop can remove ownership before the write lands.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After synchronous reset, `line_state` is 0 (invalid) and `cpu_done`, `bus_req`, `bus_cmd_vld` and `flush` are all low.
- R2: A read in invalid state moves to state 4 (read pending) with `bus_req` high. On grant, `bus_cmd` 1 (read) is issued. The line enters state 2 (exclusive) if `bus_shared` is low at the grant edge and state 1 (shared) if it is high, and `cpu_done` pulses.
- R3: A write in invalid state moves to state 5 (write-miss pending) with `bus_req` high. On grant, `bus_cmd` 2 (read-for-ownership) is issued, the line enters state 3 (modified) and `cpu_done` pulses.
- R4: A write in shared state moves to state 6 (upgrade pending), and `cpu_done` stays low until the grant. On grant, `bus_cmd` 3 (upgrade) is issued, the line enters modified and `cpu_done` pulses.
- R5: A write in exclusive state moves to modified with a `cpu_done` pulse and no bus request or command.
- R6: Reads in modified, exclusive or shared give `cpu_done` in the next cycle without changing state or raising `bus_req`.
- R7: In modified, a matching snooped read (`snp_excl`=0) gives a one-cycle `flush` and moves to shared. A matching snooped read-for-ownership (`snp_excl`=1) gives a `flush` and moves to invalid.
- R8: In exclusive, a matching snooped read moves to shared. In exclusive or shared, a matching read-for-ownership moves to invalid. Neither case raises `flush`.
- R9: In upgrade pending, a matching snooped read-for-ownership moves the line to write-miss pending, and the next grant issues `bus_cmd` 2 and ends in modified.
- R10: Snoops whose `snp_addr` differs from `line_addr` change nothing. A matching snooped read during upgrade pending leaves that state unchanged.
- R11: A matching snoop takes precedence over a processor request in the same cycle; that request is not served in that cycle.
- R12: A grant while no request is pending issues no bus command and changes no state.
- R13: A request still held in the cycle where `cpu_done` is high is not served a second time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_addr | input | ADDR_W | Block address this controller tracks |
| cpu_req | input | 1 | Processor request, held until `cpu_done` |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_done | output | 1 | Request completed (one-cycle pulse) |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Bus grant |
| bus_shared | input | 1 | Another cache holds the block, sampled at grant |
| bus_cmd_vld | output | 1 | Issued bus command valid |
| bus_cmd | output | 2 | 1 read, 2 read-for-ownership, 3 upgrade |
| snp_vld | input | 1 | Snooped transaction from another cache |
| snp_excl | input | 1 | 0 = snooped read, 1 = snooped read-for-ownership |
| snp_addr | input | ADDR_W | Snooped block address |
| flush | output | 1 | Line data must be driven onto the bus |
| line_state | output | 3 | 0 I, 1 S, 2 E, 3 M, 4 read pending, 5 write-miss pending, 6 upgrade pending |

## Verification
Every result is registered. A request, snoop or grant presented before a rising edge shows its effect on `line_state`, `cpu_done`, `bus_cmd_vld`, `bus_cmd` and `flush` directly after that edge. `bus_req` follows the state in the same cycle. The bench drives inputs on the falling edge, advances exactly one rising edge, and samples at the next falling edge. Each check therefore reads the one-cycle result of a single stimulus. Stall checks hold the request over several edges and confirm that `cpu_done` stays low and the state stays fixed on each of them.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  typedef enum logic [2:0] {
    ST_I   = 3'd0,
    ST_S   = 3'd1,
    ST_E   = 3'd2,
    ST_M   = 3'd3,
    ST_ISE = 3'd4,
    ST_IM  = 3'd5,
    ST_SM  = 3'd6
  } line_st_t;

  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_RD   = 2'd1,
    CMD_RDX  = 2'd2,
    CMD_UPG  = 2'd3
  } bus_cmd_t;

  function automatic logic is_wait(line_st_t s);
    return (s == ST_ISE) || (s == ST_IM) || (s == ST_SM);
  endfunction
endpackage

// File: rtl/mesi_snoop_match.sv
module mesi_snoop_match #(
  parameter int ADDR_W = 26
) (
  input  logic              snp_vld,
  input  logic              snp_excl,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic [ADDR_W-1:0] line_addr,
  output logic              hit_rd,
  output logic              hit_rdx
);
  logic same_blk;
  assign same_blk = snp_vld && (snp_addr == line_addr);
  assign hit_rd   = same_blk && !snp_excl;
  assign hit_rdx  = same_blk && snp_excl;
endmodule

// File: rtl/mesi_next_state.sv
module mesi_next_state
  import mesi_pkg::*;
(
  input  line_st_t cur,
  input  logic     req_ok,
  input  logic     wr,
  input  logic     gnt,
  input  logic     shared,
  input  logic     hit_rd,
  input  logic     hit_rdx,
  output line_st_t nxt,
  output logic     done_d,
  output logic     cmd_vld_d,
  output bus_cmd_t cmd_d,
  output logic     flush_d
);
  always_comb begin
    nxt       = cur;
    done_d    = 1'b0;
    cmd_vld_d = 1'b0;
    cmd_d     = CMD_NONE;
    flush_d   = 1'b0;
    unique case (cur)
      ST_I: if (req_ok) nxt = wr ? ST_IM : ST_ISE;
      ST_ISE: if (gnt) begin
        cmd_vld_d = 1'b1; cmd_d = CMD_RD; done_d = 1'b1;
        nxt = shared ? ST_S : ST_E;
      end
      ST_IM: if (gnt) begin
        cmd_vld_d = 1'b1; cmd_d = CMD_RDX; done_d = 1'b1; nxt = ST_M;
      end
      ST_SM: begin
        if (gnt) begin
          cmd_vld_d = 1'b1; cmd_d = CMD_UPG; done_d = 1'b1; nxt = ST_M;
        end else if (hit_rdx) begin
          nxt = ST_IM;
        end
      end
      ST_S: begin
        if (hit_rdx)      nxt = ST_I;
        else if (hit_rd)  nxt = ST_S;
        else if (req_ok) begin
          if (wr) nxt = ST_SM;
          else    done_d = 1'b1;
        end
      end
      ST_E: begin
        if (hit_rdx)      nxt = ST_I;
        else if (hit_rd)  nxt = ST_S;
        else if (req_ok) begin
          done_d = 1'b1;
          if (wr) nxt = ST_M;
        end
      end
      ST_M: begin
        if (hit_rdx) begin
          nxt = ST_I; flush_d = 1'b1;
        end else if (hit_rd) begin
          nxt = ST_S; flush_d = 1'b1;
        end else if (req_ok) begin
          done_d = 1'b1;
        end
      end
      default: nxt = ST_I;
    endcase
  end
endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
  import mesi_pkg::*;
#(
  parameter int ADDR_W = 26
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] line_addr,
  input  logic              cpu_req,
  input  logic              cpu_wr,
  output logic              cpu_done,
  output logic              bus_req,
  input  logic              bus_gnt,
  input  logic              bus_shared,
  output logic              bus_cmd_vld,
  output logic [1:0]        bus_cmd,
  input  logic              snp_vld,
  input  logic              snp_excl,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              flush,
  output logic [2:0]        line_state
);
  line_st_t st_q, st_d;
  logic     hit_rd, hit_rdx, req_ok;
  logic     done_d, cmd_vld_d, flush_d;
  bus_cmd_t cmd_d, cmd_q;

  mesi_snoop_match #(.ADDR_W(ADDR_W)) u_match (
    .snp_vld(snp_vld), .snp_excl(snp_excl), .snp_addr(snp_addr),
    .line_addr(line_addr), .hit_rd(hit_rd), .hit_rdx(hit_rdx)
  );

  assign req_ok = cpu_req && !cpu_done;

  mesi_next_state u_ns (
    .cur(st_q), .req_ok(req_ok), .wr(cpu_wr), .gnt(bus_gnt),
    .shared(bus_shared), .hit_rd(hit_rd), .hit_rdx(hit_rdx),
    .nxt(st_d), .done_d(done_d), .cmd_vld_d(cmd_vld_d),
    .cmd_d(cmd_d), .flush_d(flush_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_I;
      cpu_done    <= 1'b0;
      bus_cmd_vld <= 1'b0;
      cmd_q       <= CMD_NONE;
      flush       <= 1'b0;
    end else begin
      st_q        <= st_d;
      cpu_done    <= done_d;
      bus_cmd_vld <= cmd_vld_d;
      cmd_q       <= cmd_d;
      flush       <= flush_d;
    end
  end

  assign bus_req    = is_wait(st_q);
  assign bus_cmd    = cmd_q;
  assign line_state = st_q;

  // R7: a flush only follows a cycle spent in modified
  a_r7_flush_from_m: assert property (@(posedge clk) disable iff (rst)
    flush |-> $past(st_q) == ST_M);
  // R12: a command only follows a granted, pending request
  a_r12_cmd_needs_req: assert property (@(posedge clk) disable iff (rst)
    bus_cmd_vld |-> ($past(bus_req) && $past(bus_gnt)));
  // R4: an upgrade is only issued from upgrade pending
  a_r4_upg_from_sm: assert property (@(posedge clk) disable iff (rst)
    (bus_cmd_vld && bus_cmd == CMD_UPG) |-> $past(st_q) == ST_SM);
  // R5: silent write in exclusive
  a_r5_silent_write: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_E && cpu_req && cpu_wr && !cpu_done && !snp_vld)
      |=> (st_q == ST_M && !bus_cmd_vld && cpu_done));
  // R9: conflicting read-for-ownership redirects a pending upgrade
  a_r9_upg_redirect: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_SM && !bus_gnt && hit_rdx) |=> st_q == ST_IM);
  // R4: completion always leaves a stable valid state
  a_r4_done_stable: assert property (@(posedge clk) disable iff (rst)
    cpu_done |-> (st_q == ST_M || st_q == ST_E || st_q == ST_S));
endmodule

// File: tb/tb_mesi_line_ctrl.sv
`timescale 1ns/1ps
module tb_mesi_line_ctrl;
  localparam int AW = 26;
  localparam logic [AW-1:0] LA = 26'h01A3C4;
  localparam logic [AW-1:0] OA = 26'h01A3C5;

  logic clk = 0, rst = 1;
  logic cpu_req = 0, cpu_wr = 0, bus_gnt = 0, bus_shared = 0;
  logic snp_vld = 0, snp_excl = 0;
  logic [AW-1:0] snp_addr = '0;
  logic cpu_done, bus_req, bus_cmd_vld, flush;
  logic [1:0] bus_cmd;
  logic [2:0] line_state;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  mesi_line_ctrl #(.ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .line_addr(LA), .cpu_req(cpu_req), .cpu_wr(cpu_wr),
    .cpu_done(cpu_done), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .bus_shared(bus_shared), .bus_cmd_vld(bus_cmd_vld), .bus_cmd(bus_cmd),
    .snp_vld(snp_vld), .snp_excl(snp_excl), .snp_addr(snp_addr),
    .flush(flush), .line_state(line_state));

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic idle();
    cpu_req = 0; bus_gnt = 0; snp_vld = 0; bus_shared = 0;
  endtask

  task automatic snoop(logic x, logic [AW-1:0] a);
    snp_vld = 1; snp_excl = x; snp_addr = a; step(); snp_vld = 0;
  endtask

  task automatic t_reset();
    chk("R1 state", line_state, 0); chk("R1 done", cpu_done, 0);
    chk("R1 req", bus_req, 0); chk("R1 cmd_vld", bus_cmd_vld, 0);
    chk("R1 flush", flush, 0);
  endtask

  task automatic t_read_miss(logic sh, int exp_st);
    cpu_req = 1; cpu_wr = 0; step();
    chk("R2 pending state", line_state, 4); chk("R2 bus_req", bus_req, 1);
    chk("R2 stall", cpu_done, 0);
    step(); chk("R2 still stalled", cpu_done, 0);
    bus_gnt = 1; bus_shared = sh; step(); idle();
    chk("R2 cmd_vld", bus_cmd_vld, 1); chk("R2 cmd read", bus_cmd, 1);
    chk("R2 fill state", line_state, exp_st); chk("R2 done", cpu_done, 1);
    step(); chk("R2 cmd ends", bus_cmd_vld, 0); chk("R2 req drops", bus_req, 0);
  endtask

  task automatic t_read_hit(int st);
    cpu_req = 1; cpu_wr = 0; step(); idle();
    chk("R6 hit done", cpu_done, 1); chk("R6 state kept", line_state, st);
    chk("R6 no bus_req", bus_req, 0); chk("R6 no cmd", bus_cmd_vld, 0);
    step();
  endtask

  task automatic t_write_e();
    cpu_req = 1; cpu_wr = 1; step(); idle();
    chk("R5 to M", line_state, 3); chk("R5 done", cpu_done, 1);
    chk("R5 no cmd", bus_cmd_vld, 0); chk("R5 no bus_req", bus_req, 0);
    step();
  endtask

  task automatic t_snoop_m(logic x, int exp_st);
    snoop(x, LA);
    chk("R7 flush", flush, 1); chk("R7 state", line_state, exp_st);
    step(); chk("R7 flush one cycle", flush, 0);
  endtask

  task automatic t_snoop_clean(logic x, int exp_st);
    snoop(x, LA);
    chk("R8 state", line_state, exp_st); chk("R8 no flush", flush, 0);
  endtask

  task automatic t_other_addr();
    snoop(1, OA);
    chk("R10 other addr kept", line_state, 1); chk("R10 no flush", flush, 0);
  endtask

  task automatic t_snoop_priority();
    cpu_req = 1; cpu_wr = 1; snp_vld = 1; snp_excl = 0; snp_addr = LA; step();
    snp_vld = 0;
    chk("R11 req not served", line_state, 1); chk("R11 no bus_req", bus_req, 0);
    step();
    chk("R11 served after", line_state, 6);
  endtask

  task automatic t_upgrade_race();
    snp_vld = 1; snp_excl = 0; snp_addr = LA; step(); snp_vld = 0;
    chk("R10 read snoop in SM", line_state, 6);
    chk("R4 stall in SM", cpu_done, 0);
    snp_vld = 1; snp_excl = 1; step(); snp_vld = 0;
    chk("R9 redirect to IM", line_state, 5); chk("R9 still req", bus_req, 1);
    bus_gnt = 1; step(); idle();
    chk("R9 cmd rdx", bus_cmd, 2); chk("R9 cmd_vld", bus_cmd_vld, 1);
    chk("R9 state M", line_state, 3); chk("R9 done", cpu_done, 1);
    step();
  endtask

  task automatic t_idle_grant();
    bus_gnt = 1; step(); idle();
    chk("R12 no cmd", bus_cmd_vld, 0); chk("R12 state kept", line_state, 0);
  endtask

  task automatic t_upgrade();
    cpu_req = 1; cpu_wr = 1; step();
    chk("R4 to SM", line_state, 6); chk("R4 bus_req", bus_req, 1);
    for (int i = 0; i < 3; i++) begin
      step(); chk("R4 stall", cpu_done, 0);
    end
    bus_gnt = 1; step(); idle();
    chk("R4 upgrade cmd", bus_cmd, 3); chk("R4 cmd_vld", bus_cmd_vld, 1);
    chk("R4 state M", line_state, 3); chk("R4 done", cpu_done, 1);
    step();
  endtask

  task automatic t_done_once();
    cpu_req = 1; cpu_wr = 0; step();
    chk("R13 first done", cpu_done, 1);
    step(); chk("R13 no repeat", cpu_done, 0);
    idle(); step();
  endtask

  task automatic t_write_miss();
    cpu_req = 1; cpu_wr = 1; step();
    chk("R3 to IM", line_state, 5); chk("R3 bus_req", bus_req, 1);
    chk("R3 stall", cpu_done, 0);
    bus_gnt = 1; step(); idle();
    chk("R3 cmd rdx", bus_cmd, 2); chk("R3 cmd_vld", bus_cmd_vld, 1);
    chk("R3 state M", line_state, 3); chk("R3 done", cpu_done, 1);
    step();
  endtask

  initial begin
    repeat (3) step();
    rst = 0; step();
    t_reset();
    t_read_miss(0, 2);
    t_read_hit(2);
    t_write_e();
    t_read_hit(3);
    t_snoop_m(0, 1);
    t_other_addr();
    t_read_hit(1);
    t_snoop_priority();
    t_upgrade_race();
    t_snoop_m(1, 0);
    t_idle_grant();
    t_read_miss(1, 1);
    t_upgrade();
    t_done_once();
    t_snoop_m(1, 0);
    t_write_miss();
    t_snoop_m(1, 0);
    t_read_miss(0, 2);
    t_snoop_clean(0, 1);
    t_snoop_clean(1, 0);
    t_read_miss(0, 2);
    t_snoop_clean(1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule